// File: doc/BRIEF.md
# Control and Status Register Instruction Unit

This block executes the six control/status register access instructions of a 64-bit RISC-V core in machine mode. Each cycle it may receive one 32-bit instruction word together with the value of the source general-purpose register and a valid strobe. It decodes the word and reads the addressed control register from a small internal register file. It then decides whether the access writes, computes the replacement value, and returns the old value for write-back to the destination register.

All results are registered. They appear on the outputs one clock after the valid input. The internal register updates on the same edge, so an access in the very next cycle already observes the new contents. The general-purpose register file stays outside the block. The core reads the source operand from it beforehand and writes the returned data into it when the write-enable output is high.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction is accepted only when `valid_i` is high, bits [6:0] equal 7'b1110011 and bits [13:12] are non-zero. Bits [31:20] hold the register address, [19:15] the source field, [14:12] the function code and [11:7] the destination index. Function codes 001, 010 and 011 select swap, bit-set and bit-clear with the register operand. 101, 110 and 111 select the same operations with an immediate operand. Any other word leaves every output strobe low.
- R2: In the immediate forms the 5-bit source field, zero-extended to 64 bits, replaces `rs1_val_i` as the operand.
- R3: A swap always writes the control register. A set or clear writes only when the 5-bit source field is non-zero, whatever the register value is. `csr_wr_o` reports each write that takes place.
- R4: The implemented addresses are 0x300–0x306, 0x340–0x344 and 0xF11–0xF14. An access to any other address raises `illegal_o`.
- R5: An address with bits [11:10] = 2'b11 is read-only. A writing access to it raises `illegal_o`, and a non-writing access to it is legal.
- R6: The value written is the operand for a swap, old OR operand for a set, and old AND NOT operand for a clear.
- R7: A legal access returns the old register value on `rd_data_o`, with `rd_idx_o` equal to the destination field. `rd_we_o` is high only when that index is non-zero.
- R8: An illegal access changes no control register and raises none of `rd_we_o`, `csr_wr_o` and `csr_rd_o`.
- R9: `csr_rd_o` is high for every legal access, except a swap whose destination index is zero.
- R10: 0xF11–0xF14 read as zero. 0x301 reads as the parameter `ID_CONST` and ignores writes. All other implemented registers reset to zero and hold any 64-bit value.
- R11: Outputs are registered one cycle after `valid_i`. An access in the following cycle sees the value written by the previous one.
- R12: After a synchronous active-low reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Value of the source general-purpose register |
| rd_we_o | output | 1 | Write-back enable for the destination register |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | XLEN | Old control-register value for write-back |
| illegal_o | output | 1 | Illegal-instruction indication |
| csr_rd_o | output | 1 | A control register was read |
| csr_wr_o | output | 1 | A control register was written |

## Verification
The bench builds the block with XLEN = 64 and a recognisable non-zero `ID_CONST`, so the constant register can be told apart from the zero-valued read-only group. At full width, set and clear patterns that straddle bit 31 and bit 63 show that no upper bits are lost or sign-extended. The immediate forms only ever reach the low five bits. The directed tasks walk every writable slot, both operand forms, the read-only and unimplemented boundaries, and back-to-back accesses to the same register.

// File: rtl/csru_pkg.sv
// Package: shared types and constants of the control/status register unit.
// Assumes a 32-bit instruction encoding with the standard field layout.
package csru_pkg;
    localparam logic [6:0] SYS_OPCODE = 7'b1110011;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic              hit;
        csr_op_e           op;
        logic              use_imm;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  src;
        logic [IDX_W-1:0]  dst;
    } csr_dec_t;
endpackage

// File: rtl/csru_decode.sv
// Module: splits an instruction word into the fields of a register access.
// Assumes: purely combinational; hit is low for any word outside the six forms.
module csru_decode
    import csru_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    output csr_dec_t    dec_o
);
    logic [2:0] fn;
    assign fn = instr_i[14:12];

    // Field extraction and operation selection.
    always_comb begin
        dec_o.hit     = valid_i && (instr_i[6:0] == SYS_OPCODE) && (fn[1:0] != 2'b00);
        dec_o.op      = csr_op_e'(fn[1:0]);
        dec_o.use_imm = fn[2];
        dec_o.addr    = instr_i[31:20];
        dec_o.src     = instr_i[19:15];
        dec_o.dst     = instr_i[11:7];
    end
endmodule

// File: rtl/csru_file.sv
// Module: machine-mode register file with combinational read and one write port.
// Assumes: the caller writes only legal, writable addresses; 0x301 and 0xF11-0xF14
// are constants, and every other implemented address is a plain register.
module csru_file
    import csru_pkg::*;
#(
    parameter int               XLEN     = 64,
    parameter logic [XLEN-1:0]  ID_CONST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [XLEN-1:0]   rdata_o,
    output logic              impl_o,
    input  logic              we_i,
    input  logic [XLEN-1:0]   wdata_i
);
    localparam int N_LOW   = 6;  // 0x300, 0x302..0x306
    localparam int N_TRAP  = 5;  // 0x340..0x344
    localparam int N_SLOT  = N_LOW + N_TRAP;
    localparam logic [ADDR_W-1:0] ID_ADDR = 12'h301;
    localparam logic [ADDR_W-1:0] RO_LO   = 12'hF11;
    localparam logic [ADDR_W-1:0] RO_HI   = 12'hF14;

    function automatic logic [ADDR_W-1:0] slot_addr(input int i);
        if (i == 0)         return 12'h300;
        else if (i < N_LOW) return ADDR_W'(12'h301 + i);
        else                return ADDR_W'(12'h340 + (i - N_LOW));
    endfunction

    logic [XLEN-1:0] slot_q [N_SLOT];
    logic [N_SLOT-1:0] slot_sel;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        assign slot_sel[g] = (addr_i == slot_addr(g));

        // Storage of one writable register.
        always_ff @(posedge clk) begin
            if (!rst_n)                  slot_q[g] <= '0;
            else if (we_i && slot_sel[g]) slot_q[g] <= wdata_i;
        end

        a_r8_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && slot_sel[g]) |=> $stable(slot_q[g]))
            else $error("slot changed without a write");
    end

    // Read multiplexer and implemented-address decision.
    always_comb begin
        rdata_o = '0;
        impl_o  = (addr_i == ID_ADDR) || (addr_i >= RO_LO && addr_i <= RO_HI);
        if (addr_i == ID_ADDR) rdata_o = ID_CONST;
        for (int i = 0; i < N_SLOT; i++) begin
            if (slot_sel[i]) begin
                rdata_o = rdata_o | slot_q[i];
                impl_o  = 1'b1;
            end
        end
    end

    a_r4_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel))
        else $error("address selects more than one slot");
endmodule

// File: rtl/csr_exec_unit.sv
// Module: executes register-access instructions against csru_file and registers
// the write-back, illegal and strobe outputs one cycle after valid_i.
// Assumes: rs1_val_i is the source register value for the presented word.
module csr_exec_unit
    import csru_pkg::*;
#(
    parameter int              XLEN     = 64,
    parameter logic [XLEN-1:0] ID_CONST = 64'h8000_0000_0014_1101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  rs1_val_i,
    output logic             rd_we_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic [XLEN-1:0]  rd_data_o,
    output logic             illegal_o,
    output logic             csr_rd_o,
    output logic             csr_wr_o
);
    csr_dec_t        dec;
    logic [XLEN-1:0] old_val, operand, new_val;
    logic            impl, writes, read_only, legal, file_we, skip_read;

    csru_decode u_dec (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    csru_file #(.XLEN(XLEN), .ID_CONST(ID_CONST)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (dec.addr),
        .rdata_o (old_val),
        .impl_o  (impl),
        .we_i    (file_we),
        .wdata_i (new_val)
    );

    // Operand choice, write decision, legality and replacement value.
    always_comb begin
        operand   = dec.use_imm ? {{(XLEN-IDX_W){1'b0}}, dec.src} : rs1_val_i;
        writes    = (dec.op == OP_SWAP) || (dec.src != '0);
        read_only = (dec.addr[11:10] == 2'b11);
        legal     = impl && !(read_only && writes);
        file_we   = dec.hit && legal && writes;
        skip_read = (dec.op == OP_SWAP) && (dec.dst == '0);
        case (dec.op)
            OP_SET:  new_val = old_val | operand;
            OP_CLR:  new_val = old_val & ~operand;
            default: new_val = operand;
        endcase
    end

    // Output registers, loaded one cycle after the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_we_o   <= 1'b0;
            rd_idx_o  <= '0;
            rd_data_o <= '0;
            illegal_o <= 1'b0;
            csr_rd_o  <= 1'b0;
            csr_wr_o  <= 1'b0;
        end else begin
            rd_we_o   <= dec.hit && legal && (dec.dst != '0);
            rd_idx_o  <= dec.hit ? dec.dst : '0;
            rd_data_o <= (dec.hit && legal) ? old_val : '0;
            illegal_o <= dec.hit && !legal;
            csr_rd_o  <= dec.hit && legal && !skip_read;
            csr_wr_o  <= file_we;
        end
    end

    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !rd_we_o && !csr_wr_o && !csr_rd_o)
        else $error("illegal access produced a side effect");

    a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> rd_idx_o != '0)
        else $error("write-back to index zero");

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !rd_we_o && !csr_rd_o && !csr_wr_o && !illegal_o)
        else $error("output without an accepted word");

    a_r5_ro_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dec.hit && dec.addr[11:10] == 2'b11 && writes) |=> illegal_o && !csr_wr_o)
        else $error("write to read-only address accepted");
endmodule

// File: tb/csr_exec_unit_tb_top.sv
module csr_exec_unit_tb_top;
    localparam int          XLEN  = 64;
    localparam logic [63:0] IDC   = 64'h8000_0000_0014_1101;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_i = 1'b0;
    logic [31:0]     instr_i = '0;
    logic [XLEN-1:0] rs1_val_i = '0;
    logic            rd_we_o, illegal_o, csr_rd_o, csr_wr_o;
    logic [4:0]      rd_idx_o;
    logic [XLEN-1:0] rd_data_o;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    csr_exec_unit #(.XLEN(XLEN), .ID_CONST(IDC)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .rs1_val_i(rs1_val_i), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
        .rd_data_o(rd_data_o), .illegal_o(illegal_o), .csr_rd_o(csr_rd_o),
        .csr_wr_o(csr_wr_o)
    );

    function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                       input logic [2:0] f, input logic [4:0] d);
        return {a, s, f, d, 7'b1110011};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one word for one cycle; outputs are valid on return.
    task automatic issue(input logic [31:0] w, input logic [63:0] v);
        @(negedge clk);
        valid_i = 1'b1; instr_i = w; rs1_val_i = v;
        @(negedge clk);
        valid_i = 1'b0; instr_i = '0; rs1_val_i = '0;
    endtask

    // Read a register without writing it (set with source field zero).
    task automatic peek(input logic [11:0] a, output logic [63:0] val);
        issue(mk(a, 5'd0, 3'b010, 5'd9), 64'hFFFF);
        val = rd_data_o;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        chk("R12 rd_we", rd_we_o, 0); chk("R12 illegal", illegal_o, 0);
        chk("R12 csr_rd", csr_rd_o, 0); chk("R12 csr_wr", csr_wr_o, 0);
        chk("R12 rd_data", rd_data_o, 0);
        peek(12'h340, v); chk("R10 reset value", v, 0);
    endtask

    task automatic t_swap_set_clear;
        logic [63:0] v;
        issue(mk(12'h340, 5'd4, 3'b001, 5'd5), 64'hA5A5_0000_FFFF_1234);
        chk("R7 old value", rd_data_o, 0); chk("R7 idx", rd_idx_o, 5);
        chk("R7 we", rd_we_o, 1); chk("R3 swap writes", csr_wr_o, 1);
        chk("R9 read strobe", csr_rd_o, 1);
        issue(mk(12'h340, 5'd3, 3'b010, 5'd6), 64'h8000_0001_8000_0000);
        chk("R7 old after swap", rd_data_o, 64'hA5A5_0000_FFFF_1234);
        peek(12'h340, v); chk("R6 set", v, 64'hA5A5_0001_FFFF_1234 | 64'h8000_0000_8000_0000);
        issue(mk(12'h340, 5'd3, 3'b011, 5'd6), 64'h8000_0000_0000_1230);
        peek(12'h340, v); chk("R6 clear", v, 64'h25A5_0001_FFFF_0004);
    endtask

    task automatic t_immediate;
        logic [63:0] v;
        issue(mk(12'h341, 5'h1F, 3'b101, 5'd1), 64'hDEAD_BEEF_DEAD_BEEF);
        peek(12'h341, v); chk("R2 imm swap", v, 64'h1F);
        issue(mk(12'h341, 5'h00, 3'b110, 5'd1), 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 imm zero no write", csr_wr_o, 0);
        peek(12'h341, v); chk("R3 imm zero unchanged", v, 64'h1F);
        issue(mk(12'h341, 5'h01, 3'b111, 5'd1), 64'hFFFF_FFFF_FFFF_FFFF);
        peek(12'h341, v); chk("R2 imm clear", v, 64'h1E);
        issue(mk(12'h341, 5'h10, 3'b110, 5'd1), 64'h0);
        peek(12'h341, v); chk("R2 imm set", v, 64'h1E);
        issue(mk(12'h341, 5'h01, 3'b110, 5'd1), 64'h0);
        peek(12'h341, v); chk("R2 imm set bit0", v, 64'h1F);
    endtask

    task automatic t_src_field_zero;
        logic [63:0] v;
        issue(mk(12'h340, 5'd0, 3'b011, 5'd2), 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 clear x0 no write", csr_wr_o, 0);
        peek(12'h340, v); chk("R3 clear x0 unchanged", v, 64'h25A5_0001_FFFF_0004);
    endtask

    task automatic t_unimplemented;
        logic [63:0] v;
        issue(mk(12'h345, 5'd1, 3'b001, 5'd3), 64'h1234);
        chk("R4 0x345 illegal", illegal_o, 1); chk("R8 no we", rd_we_o, 0);
        chk("R8 no wr", csr_wr_o, 0); chk("R8 no rd", csr_rd_o, 0);
        issue(mk(12'h307, 5'd0, 3'b010, 5'd3), 64'h0);
        chk("R4 0x307 illegal", illegal_o, 1);
        issue(mk(12'hF15, 5'd0, 3'b010, 5'd3), 64'h0);
        chk("R4 0xF15 illegal", illegal_o, 1);
        issue(mk(12'h344, 5'd0, 3'b010, 5'd3), 64'h0);
        chk("R4 0x344 legal", illegal_o, 0);
        peek(12'h340, v); chk("R8 state kept", v, 64'h25A5_0001_FFFF_0004);
    endtask

    task automatic t_read_only;
        issue(mk(12'hF11, 5'd0, 3'b010, 5'd4), 64'h0);
        chk("R5 ro read legal", illegal_o, 0); chk("R10 ro zero", rd_data_o, 0);
        chk("R5 ro read we", rd_we_o, 1);
        issue(mk(12'hF14, 5'd0, 3'b111, 5'd4), 64'h0);
        chk("R5 ro imm read legal", illegal_o, 0);
        issue(mk(12'hF12, 5'd2, 3'b001, 5'd4), 64'h5);
        chk("R5 ro swap illegal", illegal_o, 1); chk("R8 ro swap no we", rd_we_o, 0);
        issue(mk(12'hF13, 5'd2, 3'b010, 5'd4), 64'h5);
        chk("R5 ro set illegal", illegal_o, 1);
        issue(mk(12'hF12, 5'd0, 3'b101, 5'd4), 64'h5);
        chk("R5 ro imm swap zero illegal", illegal_o, 1);
    endtask

    task automatic t_x0_dest;
        issue(mk(12'h342, 5'd7, 3'b001, 5'd0), 64'h77);
        chk("R7 x0 no we", rd_we_o, 0); chk("R9 swap x0 no read", csr_rd_o, 0);
        chk("R3 swap x0 writes", csr_wr_o, 1);
        issue(mk(12'h342, 5'd0, 3'b010, 5'd0), 64'h0);
        chk("R9 set x0 reads", csr_rd_o, 1); chk("R7 set x0 no we", rd_we_o, 0);
        issue(mk(12'h342, 5'd0, 3'b010, 5'd1), 64'h0);
        chk("R7 x0 swap took effect", rd_data_o, 64'h77);
    endtask

    task automatic t_id_const;
        logic [63:0] v;
        peek(12'h301, v); chk("R10 const read", v, IDC);
        issue(mk(12'h301, 5'd3, 3'b001, 5'd4), 64'h0);
        chk("R10 const write legal", illegal_o, 0);
        peek(12'h301, v); chk("R10 const unchanged", v, IDC);
        peek(12'hF13, v); chk("R10 F13 zero", v, 0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        valid_i = 1'b1; instr_i = mk(12'h343, 5'd8, 3'b001, 5'd3);
        rs1_val_i = 64'hF0E1_D2C3_B4A5_9687;
        @(negedge clk);
        chk("R11 first one cycle later", csr_wr_o, 1);
        instr_i = mk(12'h343, 5'd0, 3'b010, 5'd7); rs1_val_i = 64'h0;
        @(negedge clk);
        valid_i = 1'b0; instr_i = '0;
        chk("R11 second sees update", rd_data_o, 64'hF0E1_D2C3_B4A5_9687);
        chk("R11 second idx", rd_idx_o, 7);
        @(negedge clk);
        chk("R11 idle after", csr_rd_o, 0);
    endtask

    task automatic t_not_csr;
        issue(32'h0000_0013, 64'h1);
        chk("R1 other opcode we", rd_we_o, 0); chk("R1 other opcode illegal", illegal_o, 0);
        issue(mk(12'h340, 5'd1, 3'b000, 5'd2), 64'h1);
        chk("R1 funct3 000 quiet", {rd_we_o, csr_rd_o, csr_wr_o, illegal_o}, 0);
        issue(mk(12'h340, 5'd1, 3'b100, 5'd2), 64'h1);
        chk("R1 funct3 100 quiet", {rd_we_o, csr_rd_o, csr_wr_o, illegal_o}, 0);
        issue({12'h340, 5'd0, 3'b010, 5'd2, 7'b1110111}, 64'h1);
        chk("R1 near opcode quiet", csr_rd_o, 0);
    endtask

    task automatic t_all_slots;
        logic [63:0] v;
        for (int i = 0; i < 11; i++) begin
            logic [11:0] a;
            a = (i == 0) ? 12'h300 : (i < 6) ? 12'(12'h301 + i) : 12'(12'h340 + i - 6);
            issue(mk(a, 5'd1, 3'b001, 5'd0), 64'h1111_0000_0000_0000 * (i + 1) + 64'(i));
        end
        for (int i = 0; i < 11; i++) begin
            logic [11:0] a;
            a = (i == 0) ? 12'h300 : (i < 6) ? 12'(12'h301 + i) : 12'(12'h340 + i - 6);
            peek(a, v);
            chk("R10 slot readback", v, 64'h1111_0000_0000_0000 * (i + 1) + 64'(i));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_swap_set_clear();
        t_immediate();
        t_src_field_zero();
        t_unimplemented();
        t_read_only();
        t_x0_dest();
        t_id_const();
        t_back_to_back();
        t_not_csr();
        t_all_slots();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule